// File: doc/BRIEF.md
# Indexed Configuration Register Space with Per-Device Banks

This block holds the configuration space of a multi-function peripheral controller. The host reaches it through two byte-wide I/O locations. A write to the first location, the pointer port, sets an 8-bit pointer into a 256-byte register space. A read or write at the second location, the value port, then reaches the register that the pointer selects.

The lower part of the space, 0x00 to 0x2F, is shared. It holds the device selector at 0x07, two read-only identity bytes and a set of chip-wide setting bytes. The upper part, 0x30 to 0xFF, is banked. A separate copy exists for each logical device, and the selector register chooses which copy the host reaches.

Each bank drives three things on its own outputs: an activation flag, a 32-bit base address and a 32-bit interrupt setting. Bank 0xF0 to 0xFF is plain per-device storage.

Top module: `cfg_space_top`

## Requirements
- R1: The pointer port is I/O address 0x002E and the value port is 0x002F, or 0x004E and 0x004F when ALT_PORT=1. All 16 address bits must match, and a strobe at any other address changes no register.
- R2: A write to the pointer port stores the byte as the pointer. A read of the pointer port returns the pointer. Read data appears on io_rdata one clock after the read strobe and holds until the next read.
- R3: A value-port access reaches the register at the current pointer. When a read and a write reach the port in the same cycle, the read returns the value the register held before that write.
- R4: Register 0x07 holds the selected device number and reads back as that number. A write of a value of NDEV or more leaves the selection unchanged.
- R5: Registers 0x22 to 0x2F are read/write storage. They reach the same bytes whichever device is selected.
- R6: Register 0x20 reads CHIP_ID (default 0xA5) and register 0x21 reads CHIP_REV (default 0x01). Writes to them are discarded.
- R7: In the selected bank, bit 0 of register 0x31 is the activation flag and drives dev_enable[n] for device n. The register reads back as {7'b0, flag}.
- R8: Bank registers 0x60+j and 0x70+j, for j from 0 to 3, drive byte j of dev_base[32n+:32] and dev_irq[32n+:32]. Byte 0 is the least significant byte.
- R9: Bank registers 0xF0 to 0xFF are read/write storage. Each device has its own copy.
- R10: A read of any unimplemented address returns 0xFF, and a write to one is discarded. This covers 0x00 to 0x06, 0x08 to 0x1F, and every bank address other than 0x31, 0x60 to 0x63, 0x70 to 0x73 and 0xF0 to 0xFF.
- R11: After reset the pointer, the selector, io_rdata and every writable register are 0x00. All dev_enable bits are therefore low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read byte |
| dev_enable | output | NDEV | Activation flag of each device |
| dev_base | output | 32*NDEV | Base address of each device |
| dev_irq | output | 32*NDEV | Interrupt setting of each device |

## Verification
A corrupted pointer sends the next value-port access to the wrong register. The pointer is also visible directly one cycle after any pointer-port read. A wrong selector sends banked writes to another device's outputs, so the fault shows on dev_enable, dev_base or dev_irq at the next clock edge. A corrupted bank byte drives a wrong output bit continuously, and a read through the value port exposes it one cycle after the read strobe.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam logic [7:0] SEL_REG      = 8'h07;
    localparam logic [7:0] ID_REG       = 8'h20;
    localparam logic [7:0] REV_REG      = 8'h21;
    localparam logic [7:0] BANK_START   = 8'h30;
    localparam logic [7:0] ACT_REG      = 8'h31;
    localparam logic [5:0] BASE_GROUP   = 6'b011000;  // 0x60..0x63
    localparam logic [5:0] IRQ_GROUP    = 6'b011100;  // 0x70..0x73
    localparam logic [3:0] DEVCFG_GROUP = 4'hF;       // 0xF0..0xFF
    localparam logic [7:0] NO_REG       = 8'hFF;
endpackage

// File: rtl/cfg_global_regs.sv
module cfg_global_regs #(
    parameter int         NDEV     = 8,
    parameter int         SEL_W    = 3,
    parameter logic [7:0] CHIP_ID  = 8'hA5,
    parameter logic [7:0] CHIP_REV = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_wr,
    input  logic             val_wr,
    input  logic [7:0]       wdata,
    output logic [7:0]       pointer,
    output logic [SEL_W-1:0] dev_sel,
    output logic [7:0]       rdata
);
    import cfg_pkg::*;

    localparam int NSHARED = 14;  // 0x22..0x2F

    typedef struct packed {
        logic [7:0]              pointer;
        logic [SEL_W-1:0]        sel;
        logic [NSHARED-1:0][7:0] shared;
    } gstate_t;

    gstate_t    st_d, st_q;
    logic [3:0] slot;
    logic       in_shared;

    assign slot      = st_q.pointer[3:0] - 4'd2;
    assign in_shared = (st_q.pointer[7:4] == 4'h2) && (st_q.pointer[3:1] != 3'b000);

    always_comb begin
        st_d = st_q;
        if (ptr_wr) begin
            st_d.pointer = wdata;
        end
        if (val_wr) begin
            if (st_q.pointer == SEL_REG) begin
                if (int'(wdata) < NDEV) begin
                    st_d.sel = wdata[SEL_W-1:0];
                end
            end else if (in_shared) begin
                st_d.shared[slot] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = NO_REG;
        if (st_q.pointer == SEL_REG) begin
            rdata = '0;
            rdata[SEL_W-1:0] = st_q.sel;
        end else if (st_q.pointer == ID_REG) begin
            rdata = CHIP_ID;
        end else if (st_q.pointer == REV_REG) begin
            rdata = CHIP_REV;
        end else if (in_shared) begin
            rdata = st_q.shared[slot];
        end
    end

    assign pointer = st_q.pointer;
    assign dev_sel = st_q.sel;

    // R4
    sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && st_q.pointer == SEL_REG && int'(wdata) >= NDEV) |=> $stable(dev_sel));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (pointer == $past(wdata)));
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        enable,
    output logic [31:0] base,
    output logic [31:0] irq
);
    import cfg_pkg::*;

    typedef struct packed {
        logic             act;
        logic [3:0][7:0]  base;
        logic [3:0][7:0]  irq;
        logic [15:0][7:0] cfg;
    } bstate_t;

    bstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == ACT_REG) begin
                st_d.act = wdata[0];
            end else if (addr[7:2] == BASE_GROUP) begin
                st_d.base[addr[1:0]] = wdata;
            end else if (addr[7:2] == IRQ_GROUP) begin
                st_d.irq[addr[1:0]] = wdata;
            end else if (addr[7:4] == DEVCFG_GROUP) begin
                st_d.cfg[addr[3:0]] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = NO_REG;
        if (addr == ACT_REG) begin
            rdata = {7'b0, st_q.act};
        end else if (addr[7:2] == BASE_GROUP) begin
            rdata = st_q.base[addr[1:0]];
        end else if (addr[7:2] == IRQ_GROUP) begin
            rdata = st_q.irq[addr[1:0]];
        end else if (addr[7:4] == DEVCFG_GROUP) begin
            rdata = st_q.cfg[addr[3:0]];
        end
    end

    assign enable = st_q.act;
    assign base   = st_q.base;
    assign irq    = st_q.irq;

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable));

    // R7
    act_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ACT_REG) |=> (enable == $past(wdata[0])));

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(base) && $stable(irq)));
endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top #(
    parameter int         NDEV     = 8,
    parameter bit         ALT_PORT = 1'b0,
    parameter logic [7:0] CHIP_ID  = 8'hA5,
    parameter logic [7:0] CHIP_REV = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        io_addr,
    input  logic [7:0]         io_wdata,
    input  logic               io_wr,
    input  logic               io_rd,
    output logic [7:0]         io_rdata,
    output logic [NDEV-1:0]    dev_enable,
    output logic [NDEV*32-1:0] dev_base,
    output logic [NDEV*32-1:0] dev_irq
);
    import cfg_pkg::*;

    localparam int          SEL_W    = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam logic [15:0] PTR_PORT = ALT_PORT ? 16'h004E : 16'h002E;
    localparam logic [15:0] VAL_PORT = PTR_PORT + 16'd1;

    typedef struct packed {
        logic [7:0] rdata;
    } tstate_t;

    tstate_t          st_d, st_q;
    logic             hit_ptr, hit_val, ptr_wr, val_wr, banked;
    logic [7:0]       pointer, shared_rd;
    logic [SEL_W-1:0] dev_sel;
    logic [7:0]       bank_rd [NDEV];

    assign hit_ptr = (io_addr == PTR_PORT);
    assign hit_val = (io_addr == VAL_PORT);
    assign ptr_wr  = io_wr && hit_ptr;
    assign val_wr  = io_wr && hit_val;
    assign banked  = (pointer >= BANK_START);

    cfg_global_regs #(
        .NDEV     (NDEV),
        .SEL_W    (SEL_W),
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV)
    ) u_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_wr  (ptr_wr),
        .val_wr  (val_wr && !banked),
        .wdata   (io_wdata),
        .pointer (pointer),
        .dev_sel (dev_sel),
        .rdata   (shared_rd)
    );

    for (genvar k = 0; k < NDEV; k++) begin : g_bank
        cfg_dev_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (val_wr && banked && (int'(dev_sel) == k)),
            .addr   (pointer),
            .wdata  (io_wdata),
            .rdata  (bank_rd[k]),
            .enable (dev_enable[k]),
            .base   (dev_base[k*32 +: 32]),
            .irq    (dev_irq[k*32 +: 32])
        );
    end

    always_comb begin
        st_d = st_q;
        if (io_rd && hit_ptr) begin
            st_d.rdata = pointer;
        end else if (io_rd && hit_val) begin
            st_d.rdata = banked ? bank_rd[dev_sel] : shared_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata = st_q.rdata;

    // R2
    ptr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && hit_ptr) |=> (io_rdata == $past(pointer)));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

    // R6
    id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && hit_val && pointer == ID_REG) |=> (io_rdata == CHIP_ID));
endmodule

// File: tb/tb_cfg_space_top.sv
module tb_cfg_space_top;
    localparam int NDEV = 8;
    localparam logic [15:0] PP = 16'h002E;
    localparam logic [15:0] VP = 16'h002F;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [15:0]        io_addr;
    logic [7:0]         io_wdata;
    logic               io_wr, io_rd;
    logic [7:0]         io_rdata;
    logic [NDEV-1:0]    dev_enable;
    logic [NDEV*32-1:0] dev_base, dev_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } sb_item_t;
    sb_item_t sb_q[$];
    logic     rd_seen;

    always #2 clk = ~clk;

    cfg_space_top #(.NDEV(NDEV)) dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .dev_enable(dev_enable), .dev_base(dev_base), .dev_irq(dev_irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        sb_q.push_back('{exp, req});
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic rdwr(input logic [7:0] d, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = VP; io_wdata = d; io_wr = 1'b1; io_rd = 1'b1;
        sb_q.push_back('{exp, req});
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    // monitor: read data is registered on the edge after the strobe
    always @(posedge clk) rd_seen <= io_rd;

    always @(negedge clk) begin
        if (rd_seen === 1'b1) begin
            if (sb_q.size() == 0) begin
                chk(32'h1, 32'h0, "R2 unexpected read");
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk({24'b0, io_rdata}, {24'b0, it.exp}, it.req);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk({24'b0, io_rdata}, 32'h0, "R11 rdata");
        chk({24'b0, dev_enable}, 32'h0, "R11 enable");
        chk(dev_base[31:0], 32'h0, "R11 base");
        rd(PP, 8'h00, "R11 pointer");
        wr(PP, 8'h07);
        rd(VP, 8'h00, "R11 selector");

        // R2 pointer latch and read-back
        wr(PP, 8'h55);
        rd(PP, 8'h55, "R2 pointer");

        // R6 identity bytes are constant
        wr(PP, 8'h20);
        rd(VP, 8'hA5, "R6 id");
        wr(VP, 8'h00);
        rd(VP, 8'hA5, "R6 id after write");
        wr(PP, 8'h21);
        rd(VP, 8'h01, "R6 rev");

        // R4 device selection
        wr(PP, 8'h07);
        wr(VP, 8'h03);
        rd(VP, 8'h03, "R4 select");
        wr(VP, 8'h09);
        rd(VP, 8'h03, "R4 out-of-range ignored");

        // R7 activation in bank 3
        wr(PP, 8'h31);
        wr(VP, 8'hFF);
        rd(VP, 8'h01, "R7 readback");
        chk({24'b0, dev_enable}, 32'h08, "R7 enable");

        // R8 base and interrupt bytes
        wr(PP, 8'h60); wr(VP, 8'h11);
        wr(PP, 8'h61); wr(VP, 8'h22);
        wr(PP, 8'h62); wr(VP, 8'h33);
        wr(PP, 8'h63); wr(VP, 8'h44);
        wr(PP, 8'h70); wr(VP, 8'h05);
        @(negedge clk);
        chk(dev_base[3*32 +: 32], 32'h44332211, "R8 base");
        chk(dev_irq[3*32 +: 32], 32'h00000005, "R8 irq");
        chk(dev_base[0 +: 32], 32'h0, "R8 other bank base");

        // R9 per-device storage
        wr(PP, 8'hF5); wr(VP, 8'hC3);
        wr(PP, 8'h07); wr(VP, 8'h05);
        wr(PP, 8'hF5);
        rd(VP, 8'h00, "R9 other bank empty");
        wr(VP, 8'h3C);
        wr(PP, 8'h07); wr(VP, 8'h03);
        wr(PP, 8'hF5);
        rd(VP, 8'hC3, "R9 own copy kept");

        // R5 shared bytes independent of selection
        wr(PP, 8'h07); wr(VP, 8'h05);
        wr(PP, 8'h25); wr(VP, 8'h77);
        wr(PP, 8'h07); wr(VP, 8'h00);
        wr(PP, 8'h25);
        rd(VP, 8'h77, "R5 shared");

        // R1 other addresses ignored
        wr(16'h004E, 8'h40);
        wr(16'h012E, 8'h41);
        rd(PP, 8'h25, "R1 alias pointer ignored");
        wr(16'h012F, 8'h00);
        rd(VP, 8'h77, "R1 alias value ignored");

        // R3 read returns pre-write value
        rdwr(8'h99, 8'h77, "R3 same-cycle read");
        rd(VP, 8'h99, "R3 write landed");

        // R10 unimplemented addresses
        wr(PP, 8'h07); wr(VP, 8'h03);
        wr(PP, 8'h40); wr(VP, 8'h12);
        rd(VP, 8'hFF, "R10 bank hole");
        wr(PP, 8'h10); wr(VP, 8'h12);
        rd(VP, 8'hFF, "R10 shared hole");
        @(negedge clk);
        chk(dev_base[3*32 +: 32], 32'h44332211, "R10 base untouched");
        chk({24'b0, dev_enable}, 32'h08, "R10 enable untouched");

        repeat (4) @(negedge clk);
        chk(sb_q.size(), 0, "R2 scoreboard drained");
        finish_run();
    end
endmodule